// File: doc/BRIEF.md
# Analog Power Control Register with Thermal Trip Latch

This block keeps the small power-management register of a high-voltage converter channel. Software writes it through a strobe with a 12-bit data word and reads it back through a read-data output. From the register it drives three mutually exclusive channel controls: analog enable, high-impedance output, and output pulled to ground. It also drives an active-low alarm.

A die over-temperature comparator bit comes in asynchronously. It is synchronized, then qualified by a filter state machine that needs two consecutive high samples. A qualified over-temperature sets a sticky trip flag. While the flag is set, the analog section is held off whatever the power bit says. The flag stays set after the die cools, until software writes zero to it. The power bit and the output-mode bit keep their written values throughout, so clearing the flag restores the previous power state.

The filter machine has the states TF_COOL, TF_PEND and TF_HOT. A high synchronized sample moves COOL to PEND and PEND to HOT, and a low sample returns any state to COOL. A high sample in PEND or HOT raises the trip. The power machine has the states PM_OFF, PM_ON, PM_SHUT_OFF and PM_SHUT_ON. A write moves between OFF and ON as bit 2 says. A trip moves any state to the matching SHUT state. In a SHUT state, a write with bit 0 low and no trip present moves to OFF or ON, and any other write changes only the power half of the state.

Top module: `hvctl_pwr_regs`

## Requirements
- R1: After reset the read data is 0x040, analog_en is 0, out_hiz is 1, out_gnd is 0 and alarm_n is 1.
- R2: A write sets the power bit (bit 2) from wr_data[2]. analog_en is 1 exactly when the power bit is 1 and the trip flag (bit 0) is 0.
- R3: When analog_en is 0, the output-mode bit (bit 6) selects out_hiz (bit 6 = 1) or out_gnd (bit 6 = 0). When analog_en is 1, both are 0. Exactly one of the three outputs is high at any time.
- R4: rd_data shows the trip flag on bit 0, the power bit on bit 2 and the mode bit on bit 6. Bits 1, 3 to 5 and 7 to 11 always read 0, whatever was written to them.
- R5: If overtemp_in is high at rising edges k and k+1, the trip flag reads 1 and alarm_n is 0 after edge k+3, and not earlier.
- R6: An overtemp_in high at only one rising edge, with low at the edges on either side, never sets the trip flag.
- R7: Once set, the trip flag stays 1 and alarm_n stays 0 after overtemp_in falls, until a clearing write.
- R8: A write with wr_data[0] = 0 clears the trip flag, unless a qualified over-temperature is present in that cycle, in which case the flag stays set. A write with wr_data[0] = 1 never changes the flag.
- R9: While the trip flag is 1, analog_en is 0 and the output takes the powered-down mode given by bit 6. Clearing the flag with the power bit at 1 turns analog_en back on.
- R10: Writes to the power and mode bits take effect while the trip flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 12 | Write data word |
| overtemp_in | input | 1 | Asynchronous die over-temperature comparator bit |
| rd_data | output | 12 | Register image for the read multiplexer |
| analog_en | output | 1 | Analog section enable |
| out_hiz | output | 1 | Powered-down output set to high impedance |
| out_gnd | output | 1 | Powered-down output pulled to ground |
| alarm_n | output | 1 | Active-low thermal alarm |

## Verification
The assertions assume that wr_en and wr_data are synchronous to clk and stable around its rising edge. overtemp_in may change at any time, but the latency check on the alarm counts rising edges, so it assumes the input holds its level across each sampling edge. The bench drives every input on the falling edge. It makes over-temperature pulses one cycle long to test rejection, holds the input high long enough to test write priority against the trip, and runs a random phase in which over-temperature runs of varied length overlap with random writes.

// File: rtl/hvctl_pkg.sv
package hvctl_pkg;

    localparam int CTL_W    = 12;
    localparam int BIT_TRIP = 0;
    localparam int BIT_PWR  = 2;
    localparam int BIT_HIZ  = 6;

    typedef enum logic [1:0] {
        TF_COOL = 2'd0,
        TF_PEND = 2'd1,
        TF_HOT  = 2'd2
    } therm_st_t;

    typedef enum logic [1:0] {
        PM_OFF      = 2'd0,
        PM_ON       = 2'd1,
        PM_SHUT_OFF = 2'd2,
        PM_SHUT_ON  = 2'd3
    } pwr_st_t;

    // Build the read image from the three live bits; every other bit is zero.
    function automatic logic [CTL_W-1:0] ctl_image(input logic trip_bit,
                                                   input logic pwr_bit,
                                                   input logic hiz_bit);
        logic [CTL_W-1:0] img;
        img           = '0;
        img[BIT_TRIP] = trip_bit;
        img[BIT_PWR]  = pwr_bit;
        img[BIT_HIZ]  = hiz_bit;
        return img;
    endfunction

    localparam logic [CTL_W-1:0] CTL_RESET = ctl_image(1'b0, 1'b0, 1'b1);

endpackage

// File: rtl/hvctl_sync.sv
module hvctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hvctl_therm_filt.sv
module hvctl_therm_filt
    import hvctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hot_s,
    output logic trip
);

    therm_st_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TF_COOL;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = TF_COOL;
        unique case (st)
            TF_COOL: st_nx = hot_s ? TF_PEND : TF_COOL;
            TF_PEND: st_nx = hot_s ? TF_HOT  : TF_COOL;
            TF_HOT:  st_nx = hot_s ? TF_HOT  : TF_COOL;
            default: st_nx = TF_COOL;
        endcase
    end

    always_comb begin
        trip = 1'b0;
        unique case (st)
            TF_COOL: trip = 1'b0;
            TF_PEND: trip = hot_s;
            TF_HOT:  trip = hot_s;
            default: trip = 1'b0;
        endcase
    end

endmodule

// File: rtl/hvctl_pwr_fsm.sv
module hvctl_pwr_fsm
    import hvctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_pwr,
    input  logic wr_flag,
    input  logic trip,
    output logic pwr_bit,
    output logic trip_flag,
    output logic ana_en
);

    pwr_st_t pm, pm_nx;
    logic    tgt_pwr;
    logic    keep_shut;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pm <= PM_OFF;
        else        pm <= pm_nx;
    end

    // Power bit that holds after this cycle: a write replaces it, else it is kept.
    assign tgt_pwr   = wr_en ? wr_pwr : pwr_bit;
    // A hardware trip beats a software clear in the same cycle.
    assign keep_shut = trip || !(wr_en && !wr_flag);

    always_comb begin
        pm_nx = pm;
        unique case (pm)
            PM_OFF, PM_ON: begin
                if (trip)       pm_nx = tgt_pwr ? PM_SHUT_ON : PM_SHUT_OFF;
                else if (wr_en) pm_nx = wr_pwr  ? PM_ON      : PM_OFF;
            end
            PM_SHUT_OFF, PM_SHUT_ON: begin
                if (keep_shut) pm_nx = tgt_pwr ? PM_SHUT_ON : PM_SHUT_OFF;
                else           pm_nx = tgt_pwr ? PM_ON      : PM_OFF;
            end
            default: pm_nx = PM_OFF;
        endcase
    end

    always_comb begin
        pwr_bit   = 1'b0;
        trip_flag = 1'b0;
        ana_en    = 1'b0;
        unique case (pm)
            PM_OFF:      begin pwr_bit = 1'b0; trip_flag = 1'b0; ana_en = 1'b0; end
            PM_ON:       begin pwr_bit = 1'b1; trip_flag = 1'b0; ana_en = 1'b1; end
            PM_SHUT_OFF: begin pwr_bit = 1'b0; trip_flag = 1'b1; ana_en = 1'b0; end
            PM_SHUT_ON:  begin pwr_bit = 1'b1; trip_flag = 1'b1; ana_en = 1'b0; end
            default:     begin pwr_bit = 1'b0; trip_flag = 1'b0; ana_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/hvctl_pwr_regs.sv
module hvctl_pwr_regs
    import hvctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             overtemp_in,
    output logic [CTL_W-1:0] rd_data,
    output logic             analog_en,
    output logic             out_hiz,
    output logic             out_gnd,
    output logic             alarm_n
);

    logic hot_s;
    logic trip;
    logic pwr_bit;
    logic trip_flag;
    logic ana_en;
    logic hiz_bit;

    hvctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (overtemp_in),
        .q     (hot_s)
    );

    hvctl_therm_filt u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .hot_s (hot_s),
        .trip  (trip)
    );

    hvctl_pwr_fsm u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_pwr    (wr_data[BIT_PWR]),
        .wr_flag   (wr_data[BIT_TRIP]),
        .trip      (trip),
        .pwr_bit   (pwr_bit),
        .trip_flag (trip_flag),
        .ana_en    (ana_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hiz_bit <= CTL_RESET[BIT_HIZ];
        else if (wr_en) hiz_bit <= wr_data[BIT_HIZ];
    end

    always_comb begin
        rd_data   = ctl_image(trip_flag, pwr_bit, hiz_bit);
        analog_en = ana_en;
        out_hiz   = !ana_en &&  hiz_bit;
        out_gnd   = !ana_en && !hiz_bit;
        alarm_n   = !trip_flag;
    end

endmodule

// File: rtl/hvctl_pwr_regs_chk.sv
module hvctl_pwr_regs_chk
    import hvctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CTL_W-1:0] wr_data,
    input logic             overtemp_in,
    input logic [CTL_W-1:0] rd_data,
    input logic             analog_en,
    input logic             out_hiz,
    input logic             out_gnd,
    input logic             alarm_n
);

    assert_reset_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_data == CTL_RESET));

    assert_pwr_off_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_PWR]) |=> !analog_en);

    assert_one_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({analog_en, out_hiz, out_gnd}) == 1);

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[CTL_W-1:7] == '0) && (rd_data[5:3] == 3'b000) && !rd_data[1]);

    assert_trip_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_n) |-> ($past(overtemp_in, 4) && $past(overtemp_in, 3)));

    assert_trip_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n && !(wr_en && !wr_data[BIT_TRIP])) |=> !alarm_n);

    assert_trip_forces_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_n |-> !analog_en);

    assert_flag_matches_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_TRIP] == !alarm_n);

endmodule

bind hvctl_pwr_regs hvctl_pwr_regs_chk u_chk (.*);

// File: tb/tb_hvctl_pwr_regs.sv
module tb_hvctl_pwr_regs;

    localparam int CLK_P = 10;
    localparam int W     = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         overtemp_in = 1'b0;
    logic [W-1:0] rd_data;
    logic         analog_en, out_hiz, out_gnd, alarm_n;

    int total = 0;
    int bad   = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    bit m_s1, m_s2, m_b0, m_b2, m_b6;
    int m_run;

    hvctl_pwr_regs dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .overtemp_in (overtemp_in),
        .rd_data     (rd_data),
        .analog_en   (analog_en),
        .out_hiz     (out_hiz),
        .out_gnd     (out_gnd),
        .alarm_n     (alarm_n)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model: two-stage delay, then two consecutive highs set the flag
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_run = 0;
            m_b0 = 0; m_b2 = 0; m_b6 = 1;
        end else begin
            bit hot_now;
            hot_now = m_s2 && (m_run >= 1);
            m_run   = m_s2 ? ((m_run >= 1) ? 2 : 1) : 0;
            m_s2    = m_s1;
            m_s1    = overtemp_in;
            if (wr_en) begin
                m_b2 = wr_data[2];
                m_b6 = wr_data[6];
                if (!wr_data[0]) m_b0 = 0;
            end
            if (hot_now) m_b0 = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic [W-1:0] img;
            bit en;
            img = '0; img[0] = m_b0; img[2] = m_b2; img[6] = m_b6;
            en  = m_b2 && !m_b0;
            chk("R4", "model rd_data", 32'(rd_data), 32'(img));
            chk("R2", "model analog_en", 32'(analog_en), 32'(en));
            chk("R3", "model out_hiz", 32'(out_hiz), 32'(!en && m_b6));
            chk("R3", "model out_gnd", 32'(out_gnd), 32'(!en && !m_b6));
            chk("R7", "model alarm_n", 32'(alarm_n), 32'(!m_b0));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_data", 32'(rd_data), 32'h040);
        chk("R1", "analog_en", 32'(analog_en), 0);
        chk("R1", "out_hiz", 32'(out_hiz), 1);
        chk("R1", "out_gnd", 32'(out_gnd), 0);
        chk("R1", "alarm_n", 32'(alarm_n), 1);

        // R2 power up
        wr(12'h004);
        chk("R2", "rd_data", 32'(rd_data), 32'h004);
        chk("R2", "analog_en", 32'(analog_en), 1);
        chk("R3", "enabled out_hiz", 32'(out_hiz), 0);
        chk("R3", "enabled out_gnd", 32'(out_gnd), 0);

        // R4 reserved bits dropped; R8 writing 1 to bit 0 does not set it
        wr(12'hFFE);
        chk("R4", "reserved masked", 32'(rd_data), 32'h044);
        wr(12'hFFF);
        chk("R8", "bit0 write one ignored", 32'(rd_data), 32'h044);
        chk("R8", "alarm after write one", 32'(alarm_n), 1);

        // R3 modes while powered down
        wr(12'h000);
        chk("R3", "pulldown mode", 32'(out_gnd), 1);
        chk("R3", "no hiz", 32'(out_hiz), 0);
        wr(12'h040);
        chk("R3", "hiz mode", 32'(out_hiz), 1);
        chk("R3", "no pulldown", 32'(out_gnd), 0);

        // R6 single-sample pulse rejected
        overtemp_in = 1'b1;
        @(negedge clk);
        overtemp_in = 1'b0;
        cycles(6);
        chk("R6", "glitch alarm_n", 32'(alarm_n), 1);
        chk("R6", "glitch rd_data", 32'(rd_data), 32'h040);

        // R5 latency of a two-sample event, R9 forced off
        wr(12'h004);
        overtemp_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        overtemp_in = 1'b0;
        @(negedge clk);
        chk("R5", "alarm not yet", 32'(alarm_n), 1);
        @(negedge clk);
        chk("R5", "alarm set", 32'(alarm_n), 0);
        chk("R5", "flag read", 32'(rd_data), 32'h005);
        chk("R9", "analog forced off", 32'(analog_en), 0);
        chk("R9", "pulldown during trip", 32'(out_gnd), 1);

        // R7 sticky after cooling
        cycles(10);
        chk("R7", "still alarmed", 32'(alarm_n), 0);

        // R10 mode/power writes accepted while tripped
        wr(12'h041);
        chk("R10", "write during trip", 32'(rd_data), 32'h041);
        chk("R10", "hiz during trip", 32'(out_hiz), 1);
        wr(12'h005);
        chk("R10", "power bit during trip", 32'(rd_data), 32'h005);
        chk("R9", "still off", 32'(analog_en), 0);

        // R8 clear refused while hot, accepted after cooling
        overtemp_in = 1'b1;
        cycles(8);
        wr(12'h004);
        chk("R8", "clear while hot", 32'(rd_data), 32'h005);
        overtemp_in = 1'b0;
        cycles(5);
        chk("R7", "alarm after hot ends", 32'(alarm_n), 0);
        wr(12'h004);
        chk("R8", "clear accepted", 32'(rd_data), 32'h004);
        chk("R8", "alarm released", 32'(alarm_n), 1);
        chk("R9", "analog restored", 32'(analog_en), 1);

        // random phase checked against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 8) == 0) overtemp_in = ~overtemp_in;
            wr_en   = (($urandom % 4) == 0);
            wr_data = W'($urandom);
            @(negedge clk);
        end
        wr_en = 1'b0;
        overtemp_in = 1'b0;
        cycles(4);
        finish_run();
    end

endmodule